// File: doc/BRIEF.md
# Three-Stage Shuffle-Exchange Switching Fabric

This block joins eight sources to eight destinations through three ranks of 2x2 switchboxes, four boxes per rank. Ahead of each rank the lanes are rewired in the perfect-shuffle pattern: the lane at index i moves to index i rotated left by one bit. Each box then sets itself straight or crossed by looking at one bit of the destination address carried by the lane. The data path is combinational, so a source that finds a free path is connected in the same cycle it raises its request. Each box records which of its inputs owns each output, so a connection that has been made stays in place while its source keeps asking for it.

Every source-destination pair has exactly one path through the fabric. Some sets of requests therefore cannot all be served at once, even when every destination is different. When two requests meet at the same box output, one of them moves on and the other is stopped at that box. The losing source sees a blocked flag until the conflict clears. A request that is stopped deep in the fabric still occupies the outputs it won in the earlier ranks.

Top module: `shuffle_fabric`

## Requirements
- R1: Reset clears all ownership state. With no source valid after reset, src_grant, src_blocked and dst_valid are all zero.
- R2: A lone request from any source s to any destination d is granted in the same cycle. In that cycle dst_valid[d]=1, dst_data[d] equals the data of source s, and dst_src[d]=s.
- R3: Rank k (k=0 first) steers on destination bit 2-k, where 0 selects the box's upper output and 1 its lower output. Before each rank the lane at index i moves to index {i[1:0],i[2]}. Box j takes lanes 2j (upper) and 2j+1 (lower). Source s heading to d therefore meets rank k at box ((s<<k)|(d>>(3-k))) mod 4, on the upper input when bit 2-k of s is 0. All 64 pairs deliver.
- R4: When the two inputs of a box ask for different outputs, both connect in the same cycle. Every cyclic shift d=(s+c) mod 8 with all eight sources valid is fully granted.
- R5: When both inputs of a box ask for the same output and neither owns it, the upper input wins and the lower one is blocked.
- R6: An input that owned an output in the previous cycle and still asks for it keeps it, even against a request on the upper input.
- R7: When the owner of an output drops its request, a waiting request takes that output in the same cycle.
- R8: src_blocked[s] is high exactly when src_valid[s] is high and src_grant[s] is low. A grant is never given without a valid request.
- R9: A request that loses at a later rank still holds the outputs it won in earlier ranks, and those outputs are denied to other requests.
- R10: A destination lane with dst_valid low drives zero on dst_src and dst_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 8 | Request flag per source |
| src_dest | input | 24 | Destination address per source, 3 bits each, source s at [3s+2:3s] |
| src_data | input | 64 | Payload per source, 8 bits each, source s at [8s+7:8s] |
| src_grant | output | 8 | Complete path established per source |
| src_blocked | output | 8 | Source requesting but stopped inside the fabric |
| dst_valid | output | 8 | Connection present at each destination |
| dst_src | output | 24 | Index of the source connected to each destination |
| dst_data | output | 64 | Payload delivered to each destination |

## Verification
The two functions that meet in one cycle are ownership holding and upper-input priority. They collide when a box's lower input already owns an output and a new request for the same output arrives on the upper input. The bench provokes this directly: it connects a lower-input source alone, then adds the conflicting upper-input source. The owner must keep its grant while the newcomer is blocked. Dropping the owner must then hand the output over within that cycle. Long pseudo-random sequences with sticky requests repeat this collision at every rank, and each cycle is judged against a bench model that walks the ranks and switch indices arithmetically.

// File: rtl/sf_pkg.sv
package sf_pkg;

    localparam int SF_STAGES = 3;
    localparam int SF_PORTS  = 1 << SF_STAGES;
    localparam int SF_BOXES  = SF_PORTS / 2;
    localparam int SF_DATA_W = 8;

    typedef logic [SF_STAGES-1:0] port_id_t;

    typedef struct packed {
        logic                 valid;
        port_id_t             src;
        port_id_t             dest;
        logic [SF_DATA_W-1:0] data;
    } lane_t;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_UPPER = 2'd1,
        OWN_LOWER = 2'd2
    } owner_e;

    // Perfect shuffle: lane index rotated left by one bit.
    function automatic int shuffle_to(input int idx);
        return ((idx << 1) | (idx >> (SF_STAGES - 1))) & (SF_PORTS - 1);
    endfunction

endpackage

// File: rtl/sf_switchbox.sv
module sf_switchbox
    import sf_pkg::*;
#(
    parameter int STEER_BIT = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  lane_t in_up,
    input  lane_t in_lo,
    output lane_t out_up,
    output lane_t out_lo
);

    owner_e     own_q [2];
    owner_e     own_d [2];
    logic [1:0] want_up;
    logic [1:0] want_lo;

    always_comb begin
        want_up = '0;
        want_lo = '0;
        if (in_up.valid) want_up[in_up.dest[STEER_BIT]] = 1'b1;
        if (in_lo.valid) want_lo[in_lo.dest[STEER_BIT]] = 1'b1;
        for (int o = 0; o < 2; o++) begin
            if (own_q[o] == OWN_LOWER && want_lo[o])
                own_d[o] = OWN_LOWER;
            else if (own_q[o] == OWN_UPPER && want_up[o])
                own_d[o] = OWN_UPPER;
            else if (want_up[o])
                own_d[o] = OWN_UPPER;
            else if (want_lo[o])
                own_d[o] = OWN_LOWER;
            else
                own_d[o] = OWN_NONE;
        end
    end

    always_comb begin
        case (own_d[0])
            OWN_UPPER: out_up = in_up;
            OWN_LOWER: out_up = in_lo;
            default:   out_up = '0;
        endcase
        case (own_d[1])
            OWN_UPPER: out_lo = in_up;
            OWN_LOWER: out_lo = in_lo;
            default:   out_lo = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        for (int o = 0; o < 2; o++) begin
            if (rst) own_q[o] <= OWN_NONE;
            else     own_q[o] <= own_d[o];
        end
    end

endmodule

// File: rtl/sf_stage.sv
module sf_stage
    import sf_pkg::*;
#(
    parameter int STAGE = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  lane_t lanes_in  [SF_PORTS],
    output lane_t lanes_out [SF_PORTS]
);

    localparam int STEER = SF_STAGES - 1 - STAGE;

    lane_t shuffled [SF_PORTS];

    for (genvar i = 0; i < SF_PORTS; i++) begin : g_wire
        assign shuffled[shuffle_to(i)] = lanes_in[i];
    end

    for (genvar j = 0; j < SF_BOXES; j++) begin : g_box
        sf_switchbox #(.STEER_BIT(STEER)) u_box (
            .clk    (clk),
            .rst    (rst),
            .in_up  (shuffled[2*j]),
            .in_lo  (shuffled[2*j+1]),
            .out_up (lanes_out[2*j]),
            .out_lo (lanes_out[2*j+1])
        );
    end

endmodule

// File: rtl/shuffle_fabric.sv
module shuffle_fabric
    import sf_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [SF_PORTS-1:0]           src_valid,
    input  logic [SF_PORTS*SF_STAGES-1:0] src_dest,
    input  logic [SF_PORTS*SF_DATA_W-1:0] src_data,
    output logic [SF_PORTS-1:0]           src_grant,
    output logic [SF_PORTS-1:0]           src_blocked,
    output logic [SF_PORTS-1:0]           dst_valid,
    output logic [SF_PORTS*SF_STAGES-1:0] dst_src,
    output logic [SF_PORTS*SF_DATA_W-1:0] dst_data
);

    lane_t lanes [SF_STAGES+1][SF_PORTS];

    for (genvar i = 0; i < SF_PORTS; i++) begin : g_entry
        always_comb begin
            lanes[0][i] = '0;
            if (src_valid[i]) begin
                lanes[0][i].valid = 1'b1;
                lanes[0][i].src   = port_id_t'(i);
                lanes[0][i].dest  = src_dest[i*SF_STAGES +: SF_STAGES];
                lanes[0][i].data  = src_data[i*SF_DATA_W +: SF_DATA_W];
            end
        end
    end

    for (genvar k = 0; k < SF_STAGES; k++) begin : g_rank
        sf_stage #(.STAGE(k)) u_stage (
            .clk       (clk),
            .rst       (rst),
            .lanes_in  (lanes[k]),
            .lanes_out (lanes[k+1])
        );
    end

    for (genvar d = 0; d < SF_PORTS; d++) begin : g_exit
        assign dst_valid[d]                         = lanes[SF_STAGES][d].valid;
        assign dst_src[d*SF_STAGES +: SF_STAGES]    = lanes[SF_STAGES][d].src;
        assign dst_data[d*SF_DATA_W +: SF_DATA_W]   = lanes[SF_STAGES][d].data;
    end

    always_comb begin
        src_grant = '0;
        for (int d = 0; d < SF_PORTS; d++) begin
            if (lanes[SF_STAGES][d].valid && lanes[SF_STAGES][d].dest == port_id_t'(d))
                src_grant[lanes[SF_STAGES][d].src] = 1'b1;
        end
    end

    assign src_blocked = src_valid & ~src_grant;

endmodule

// File: rtl/sf_checker.sv
module sf_checker
    import sf_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic [SF_PORTS-1:0]           src_valid,
    input logic [SF_PORTS*SF_STAGES-1:0] src_dest,
    input logic [SF_PORTS*SF_DATA_W-1:0] src_data,
    input logic [SF_PORTS-1:0]           src_grant,
    input logic [SF_PORTS-1:0]           src_blocked,
    input logic [SF_PORTS-1:0]           dst_valid,
    input logic [SF_PORTS*SF_STAGES-1:0] dst_src,
    input logic [SF_PORTS*SF_DATA_W-1:0] dst_data
);

    // Every granted source occupies exactly one destination lane.
    p_grant_count_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(src_grant) == $countones(dst_valid));

    for (genvar i = 0; i < SF_PORTS; i++) begin : g_src
        p_grant_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
            src_grant[i] |-> src_valid[i]);

        p_grant_or_block_r8: assert property (@(posedge clk) disable iff (rst)
            !(src_grant[i] && src_blocked[i]));

        p_keep_owned_r6: assert property (@(posedge clk) disable iff (rst)
            (src_valid[i] && $past(src_valid[i]) && $past(src_grant[i]) && $past(!rst)
             && src_dest[i*SF_STAGES +: SF_STAGES] == $past(src_dest[i*SF_STAGES +: SF_STAGES]))
            |-> src_grant[i]);
    end

    for (genvar d = 0; d < SF_PORTS; d++) begin : g_dst
        port_id_t sid;
        assign sid = dst_src[d*SF_STAGES +: SF_STAGES];

        p_delivery_r2: assert property (@(posedge clk) disable iff (rst)
            dst_valid[d] |-> (src_valid[sid] && src_grant[sid]
                && src_dest[int'(sid)*SF_STAGES +: SF_STAGES] == port_id_t'(d)
                && dst_data[d*SF_DATA_W +: SF_DATA_W] == src_data[int'(sid)*SF_DATA_W +: SF_DATA_W]));

        p_idle_lane_r10: assert property (@(posedge clk) disable iff (rst)
            !dst_valid[d] |-> (sid == '0 && dst_data[d*SF_DATA_W +: SF_DATA_W] == '0));
    end

endmodule

bind shuffle_fabric sf_checker u_sf_checker (.*);

// File: tb/tb_shuffle_fabric.sv
module tb_shuffle_fabric;
    import sf_pkg::*;

    localparam int S = SF_STAGES;
    localparam int P = SF_PORTS;
    localparam int W = SF_DATA_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [P-1:0]     src_valid = '0;
    logic [P*S-1:0]   src_dest  = '0;
    logic [P*W-1:0]   src_data  = '0;
    logic [P-1:0]     src_grant, src_blocked, dst_valid;
    logic [P*S-1:0]   dst_src;
    logic [P*W-1:0]   dst_data;

    int errors = 0;
    int checks = 0;
    int hold_m [S][SF_BOXES][2];
    int next_m [S][SF_BOXES][2];
    logic [P-1:0] exp_grant;
    logic [31:0]  lfsr = 32'hACE1_2468;

    always #4 clk = ~clk;

    shuffle_fabric dut (.*);

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int dest_of(input int s);
        return int'(src_dest[s*S +: S]);
    endfunction

    // Walk the ranks: box index and input side from the source/destination bits.
    task automatic model_eval();
        bit live [P];
        for (int s = 0; s < P; s++) live[s] = src_valid[s];
        for (int k = 0; k < S; k++) begin
            int cu [SF_BOXES][2];
            int cl [SF_BOXES][2];
            for (int b = 0; b < SF_BOXES; b++)
                for (int o = 0; o < 2; o++) begin cu[b][o] = -1; cl[b][o] = -1; end
            for (int s = 0; s < P; s++) begin
                if (live[s]) begin
                    int d = dest_of(s);
                    int b = ((s << k) | (d >> (S - k))) & (SF_BOXES - 1);
                    int side = (s >> (S - 1 - k)) & 1;
                    int o = (d >> (S - 1 - k)) & 1;
                    if (side == 0) cu[b][o] = s; else cl[b][o] = s;
                end
            end
            for (int b = 0; b < SF_BOXES; b++)
                for (int o = 0; o < 2; o++) begin
                    int w;
                    if (hold_m[k][b][o] == 2 && cl[b][o] >= 0)      w = 2;
                    else if (hold_m[k][b][o] == 1 && cu[b][o] >= 0) w = 1;
                    else if (cu[b][o] >= 0)                         w = 1;
                    else if (cl[b][o] >= 0)                         w = 2;
                    else                                            w = 0;
                    if (w == 1 && cl[b][o] >= 0) live[cl[b][o]] = 0;
                    if (w == 2 && cu[b][o] >= 0) live[cu[b][o]] = 0;
                    next_m[k][b][o] = w;
                end
        end
        for (int s = 0; s < P; s++) exp_grant[s] = live[s];
    endtask

    task automatic run_cycle(input string gtag, input string dtag);
        logic [P-1:0]   ev;
        logic [P*S-1:0] es;
        logic [P*W-1:0] ed;
        #1;
        model_eval();
        ev = '0; es = '0; ed = '0;
        for (int s = 0; s < P; s++) begin
            if (exp_grant[s]) begin
                int d = dest_of(s);
                ev[d] = 1'b1;
                es[d*S +: S] = S'(s);
                ed[d*W +: W] = src_data[s*W +: W];
            end
        end
        check(src_grant === exp_grant, gtag, "src_grant", 64'(src_grant), 64'(exp_grant));
        check(src_blocked === (src_valid & ~exp_grant), "R8", "src_blocked",
              64'(src_blocked), 64'(src_valid & ~exp_grant));
        check(dst_valid === ev && dst_src === es && dst_data === ed, dtag, "dst_data",
              dst_data, ed);
        @(posedge clk);
        hold_m = next_m;
        @(negedge clk);
    endtask

    task automatic drive(input int s, input bit v, input int d);
        src_valid[s] = v;
        src_dest[s*S +: S] = S'(d);
        src_data[s*W +: W] = W'(s * 16 + d + 1);
    endtask

    task automatic clear_all();
        src_valid = '0; src_dest = '0; src_data = '0;
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expected=finish actual=timeout");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < S; k++)
            for (int b = 0; b < SF_BOXES; b++) begin hold_m[k][b][0] = 0; hold_m[k][b][1] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: idle after reset
        run_cycle("R1", "R1");
        check(src_grant == '0 && dst_valid == '0 && src_blocked == '0, "R1", "idle",
              64'({src_grant, dst_valid}), 64'd0);

        // R2/R3: every single pair
        for (int s = 0; s < P; s++)
            for (int d = 0; d < P; d++) begin
                clear_all(); drive(s, 1'b1, d);
                run_cycle("R2", "R3");
            end

        // R4: cyclic shifts, all eight sources
        for (int c = 0; c < P; c++) begin
            clear_all();
            for (int s = 0; s < P; s++) drive(s, 1'b1, (s + c) % P);
            run_cycle("R4", "R4");
            check(src_grant == '1, "R4", "shift full grant", 64'(src_grant), 64'hFF);
        end
        clear_all(); run_cycle("R10", "R10");

        // R5: source 0 (upper) and source 4 (lower) meet at rank 0 box 0
        drive(0, 1'b1, 0); drive(4, 1'b1, 1);
        run_cycle("R5", "R5");
        check(src_grant == 8'h01 && src_blocked == 8'h10, "R5", "upper wins",
              64'({src_grant, src_blocked}), 64'h0110);
        clear_all(); run_cycle("R10", "R10");

        // R6: lower input owns first, then upper arrives
        drive(4, 1'b1, 1);
        run_cycle("R6", "R6");
        drive(0, 1'b1, 0);
        run_cycle("R6", "R6");
        check(src_grant == 8'h10 && src_blocked == 8'h01, "R6", "owner kept",
              64'({src_grant, src_blocked}), 64'h1001);

        // R7: owner drops, waiting request takes over in the same cycle
        drive(4, 1'b0, 1);
        run_cycle("R7", "R7");
        check(src_grant == 8'h01 && dst_valid == 8'h01, "R7", "handover",
              64'({src_grant, dst_valid}), 64'h0101);
        clear_all(); run_cycle("R10", "R10");

        // R9: sticky pseudo-random traffic, conflicts at every rank
        for (int n = 0; n < 4000; n++) begin
            for (int s = 0; s < P; s++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                if (lfsr[2:0] == 3'd0) begin
                    src_valid[s] = lfsr[5] | lfsr[6];
                    src_dest[s*S +: S] = lfsr[10:8];
                end
                src_data[s*W +: W] = lfsr[23:16];
            end
            run_cycle("R9", "R2");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule